// File: doc/BRIEF.md
# Page-Mode Memory Strobe and Serial-Clock Timeout Guard

This block runs beside an external page-mode memory controller on a 32-bit processor bus. It has three jobs. It times how long the row and column strobes have been held active. It times how long the serial clock of a video RAM has gone without a rising edge. It tracks which memory bank holds the open page.

Page mode keeps the strobes asserted for a long time, and the memory allows only a limited active time. The guard asks for a refresh cycle a fixed margin of 16 clocks before a programmable limit, and that refresh takes both strobes inactive. The video RAM shift register is dynamic and loses its contents if the serial clock stops. When the serial clock has been idle too long, a sticky flag tells the controller to discard the effect of the next external bus cycle and to reload the shift register in its place.

A bus cycle that goes to a different bank than the open one is reported as a page miss. So is the first access when no page is open, either after reset or after a refresh has closed the page. DMA cycles look like any other bus cycle and are treated the same way. Each of the three outputs is held until the controller returns a one-cycle acknowledge.

Top module: `pm_timeout_guard`

## Requirements
- R1: After reset, refresh_req, cancel_next_cycle and page_miss are all 0.
- R2: With strobe_active held at 1 and strobe_limit greater than 16, refresh_req first reads 1 exactly strobe_limit-15 clocks after strobe_active is first sampled high. That is, the request comes 16 clocks before the active count could reach strobe_limit.
- R3: Once raised, refresh_req stays at 1 while refresh_ack is 0. It reads 0 in the clock after refresh_ack is sampled at 1, provided strobe_active is 0.
- R4: One clock with strobe_active at 0 sets the active count back to zero. Active stretches shorter than the threshold never raise refresh_req.
- R5: When strobe_limit is 16 or less, the threshold is zero and refresh_req reads 1 one clock after strobe_active is first sampled high.
- R6: The serial-clock idle count restarts when cancel_ack is sampled at 1. With sclk held steady after that, cancel_next_cycle reads 1 exactly sclk_limit+1 clocks after the acknowledge.
- R7: sclk passes through a two-flop synchronizer. Every rising edge detected on it clears the idle count, so a serial clock toggling with a period shorter than the limit keeps cancel_next_cycle at 0.
- R8: cancel_next_cycle is sticky. Serial-clock edges that resume afterwards do not clear it. It reads 0 in the clock after cancel_ack is sampled at 1.
- R9: bank_sel is a one-hot vector with one bit for each bank. A bus_start to a bank different from the open one, or a bus_start while no page is open (the first access after reset), sets page_miss. A bus_start to the open bank does not set it.
- R10: A refresh acknowledge closes the open page, so the next bus_start is a page miss even when it goes to the same bank.
- R11: page_miss stays at 1 while page_miss_ack is 0. It reads 0 in the clock after page_miss_ack is sampled at 1, provided no new miss arrives in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strobe_active | input | 1 | Row and column strobes are currently held active |
| strobe_limit | input | CNT_W | Maximum strobe active time, in clocks |
| refresh_req | output | 1 | Request for a refresh cycle that takes both strobes inactive |
| refresh_ack | input | 1 | One-cycle acknowledge of refresh_req |
| sclk | input | 1 | Video RAM serial clock, asynchronous to clk |
| sclk_limit | input | CNT_W | Maximum serial-clock idle time, in clocks |
| cancel_next_cycle | output | 1 | Sticky flag: discard the next bus cycle and reload the shift register |
| cancel_ack | input | 1 | One-cycle acknowledge that the reload cycle has run |
| bus_start | input | 1 | Start of an external bus cycle, CPU or DMA |
| bank_sel | input | NUM_BANKS | One-hot bank strobe enable of that bus cycle |
| page_miss | output | 1 | The bus cycle missed the open page |
| page_miss_ack | input | 1 | One-cycle acknowledge of page_miss |

## Verification
The bench builds the block with CNT_W of 10 and NUM_BANKS of 4. With these values, strobe limits of 10, 17 and 40 clocks and a serial-clock limit of 20 clocks can be driven directly from the ports. That places both sides of the 16-clock margin, the exact request cycle, and the starvation window within a few dozen clocks. Four banks are enough for the bench to switch between different one-hot selects and to return to the open bank.

// File: rtl/pm_guard_pkg.sv
package pm_guard_pkg;
  // Clocks of headroom between the refresh request and the strobe limit.
  localparam int unsigned REFRESH_MARGIN = 16;
  // Depth of the serial-clock synchronizer.
  localparam int unsigned SCLK_SYNC_DEPTH = 2;
endpackage

// File: rtl/pmg_strobe_timer.sv
module pmg_strobe_timer
  import pm_guard_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             ack_i,
  output logic             req_o
);
  localparam logic [CNT_W-1:0] MARGIN = CNT_W'(REFRESH_MARGIN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] thresh;
  logic             req_q, req_d;
  logic             hit;

  always_comb begin
    thresh = (limit_i > MARGIN) ? (limit_i - MARGIN) : '0;
    hit    = active_i && (cnt_q >= thresh);
    if (!active_i)          cnt_d = '0;
    else if (cnt_q != '1)   cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q;
    req_d = req_q ? !ack_i : hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

  // R2: without a pending request the count stays under the limit
  p_req_before_limit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !req_q && (limit_i > MARGIN) && !$past(ack_i)) |-> (cnt_q < limit_i));
  // R3: the request is held until it is acknowledged
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q);
  p_req_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && ack_i) |=> !req_q);
  // R4: a request only appears while the strobes are active
  p_req_needs_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(active_i));
endmodule

// File: rtl/pmg_sclk_monitor.sv
module pmg_sclk_monitor
  import pm_guard_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             ack_i,
  output logic             stale_o
);
  localparam int unsigned DEPTH = SCLK_SYNC_DEPTH;

  logic [DEPTH-1:0] sync_q;
  logic             prev_q;
  logic             rise;
  logic [CNT_W-1:0] idle_q, idle_d;
  logic             stale_q, stale_d;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= sclk_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_comb begin
    rise = sync_q[DEPTH-1] && !prev_q;
    if (rise || ack_i)       idle_d = '0;
    else if (idle_q != '1)   idle_d = idle_q + 1'b1;
    else                     idle_d = idle_q;
    stale_d = stale_q ? !ack_i : ((idle_q >= limit_i) && !ack_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      idle_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      prev_q  <= sync_q[DEPTH-1];
      idle_q  <= idle_d;
      stale_q <= stale_d;
    end
  end

  assign stale_o = stale_q;

  // R8: the flag survives until the reload is acknowledged
  p_stale_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stale_q && !ack_i) |=> stale_q);
  p_stale_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stale_q && ack_i) |=> !stale_q);
  // R6: an acknowledge restarts the idle window
  p_ack_restarts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !stale_q);
endmodule

// File: rtl/pmg_bank_tracker.sv
module pmg_bank_tracker #(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [NUM_BANKS-1:0] bank_i,
  input  logic                 close_i,
  input  logic                 ack_i,
  output logic                 miss_o
);
  logic [NUM_BANKS-1:0] last_q, last_d;
  logic                 open_q, open_d;
  logic                 miss_q, miss_d;
  logic                 new_miss;

  always_comb begin
    new_miss = start_i && (!open_q || (bank_i != last_q));
    last_d   = last_q;
    open_d   = open_q;
    if (start_i) begin
      last_d = bank_i;
      open_d = 1'b1;
    end else if (close_i) begin
      open_d = 1'b0;
    end
    miss_d = (miss_q && !ack_i) || new_miss;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      open_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      last_q <= last_d;
      open_q <= open_d;
      miss_q <= miss_d;
    end
  end

  assign miss_o = miss_q;

  // R11: a miss is held until acknowledged
  p_miss_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_q && !ack_i) |=> miss_q);
  // R9 / R10: an access with no open page always misses
  p_closed_page_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !open_q) |=> miss_q);
  // R9: the select is one-hot on every access
  p_onehot_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ($countones(bank_i) == 1));
endmodule

// File: rtl/pm_timeout_guard.sv
module pm_timeout_guard #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe_active,
  input  logic [CNT_W-1:0]     strobe_limit,
  output logic                 refresh_req,
  input  logic                 refresh_ack,
  input  logic                 sclk,
  input  logic [CNT_W-1:0]     sclk_limit,
  output logic                 cancel_next_cycle,
  input  logic                 cancel_ack,
  input  logic                 bus_start,
  input  logic [NUM_BANKS-1:0] bank_sel,
  output logic                 page_miss,
  input  logic                 page_miss_ack
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pmg_strobe_timer #(.CNT_W(CNT_W)) u_strobe (
    .clk_i   (clk),
    .rst_ni  (rst_int_n),
    .active_i(strobe_active),
    .limit_i (strobe_limit),
    .ack_i   (refresh_ack),
    .req_o   (refresh_req)
  );

  pmg_sclk_monitor #(.CNT_W(CNT_W)) u_sclk (
    .clk_i  (clk),
    .rst_ni (rst_int_n),
    .sclk_i (sclk),
    .limit_i(sclk_limit),
    .ack_i  (cancel_ack),
    .stale_o(cancel_next_cycle)
  );

  pmg_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_bank (
    .clk_i  (clk),
    .rst_ni (rst_int_n),
    .start_i(bus_start),
    .bank_i (bank_sel),
    .close_i(refresh_ack),
    .ack_i  (page_miss_ack),
    .miss_o (page_miss)
  );

  // R1: outputs are idle while the internal reset is held
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_int_n |=> (!refresh_req && !cancel_next_cycle && !page_miss) || rst_int_n);
endmodule

// File: tb/pm_timeout_guard_bench.sv
module pm_timeout_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int NB         = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strobe_active, refresh_ack, sclk, cancel_ack, bus_start, page_miss_ack;
  logic [CNT_W-1:0] strobe_limit, sclk_limit;
  logic [NB-1:0] bank_sel;
  logic          refresh_req, cancel_next_cycle, page_miss;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_timeout_guard #(.CNT_W(CNT_W), .NUM_BANKS(NB)) u_pm_timeout_guard (
    .clk(clk), .rst_n(rst_n),
    .strobe_active(strobe_active), .strobe_limit(strobe_limit),
    .refresh_req(refresh_req), .refresh_ack(refresh_ack),
    .sclk(sclk), .sclk_limit(sclk_limit),
    .cancel_next_cycle(cancel_next_cycle), .cancel_ack(cancel_ack),
    .bus_start(bus_start), .bank_sel(bank_sel),
    .page_miss(page_miss), .page_miss_ack(page_miss_ack)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_until_req(output int n);
    n = 0;
    while (!refresh_req && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic count_until_cancel(output int n);
    n = 0;
    while (!cancel_next_cycle && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_refresh_ack();
    refresh_ack = 1'b1; strobe_active = 1'b0;
    @(negedge clk); refresh_ack = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; strobe_active = 0; refresh_ack = 0; sclk = 0; cancel_ack = 0;
    bus_start = 0; page_miss_ack = 0; bank_sel = '0;
    strobe_limit = 10'd40; sclk_limit = 10'd1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!refresh_req && !cancel_next_cycle && !page_miss, "R1 reset outputs",
          {refresh_req, cancel_next_cycle, page_miss}, 0);
  endtask

  task automatic t_strobe_threshold(input int lim);
    int n;
    strobe_limit = CNT_W'(lim);
    strobe_active = 1'b1;
    count_until_req(n);
    check(n == lim - 15, "R2 refresh request cycle", n, lim - 15);
    repeat (3) @(negedge clk);
    check(refresh_req, "R3 request held without ack", refresh_req, 1);
    pulse_refresh_ack();
    check(!refresh_req, "R3 request dropped after ack", refresh_req, 0);
  endtask

  task automatic t_short_pulses();
    bit seen = 1'b0;
    strobe_limit = 10'd40;
    for (int k = 0; k < 4; k++) begin
      strobe_active = 1'b1;
      for (int c = 0; c < 20; c++) begin @(negedge clk); seen |= refresh_req; end
      strobe_active = 1'b0;
      @(negedge clk); seen |= refresh_req;
    end
    check(!seen, "R4 short active stretches raise no request", seen, 0);
  endtask

  task automatic t_small_limit();
    int n;
    strobe_limit = 10'd10;
    strobe_active = 1'b1;
    count_until_req(n);
    check(n == 1, "R5 zero threshold request", n, 1);
    pulse_refresh_ack();
  endtask

  task automatic t_sclk_idle();
    int n;
    sclk = 1'b0;
    sclk_limit = 10'd20;
    cancel_ack = 1'b1; @(negedge clk); cancel_ack = 1'b0;
    check(!cancel_next_cycle, "R6 clear after ack", cancel_next_cycle, 0);
    count_until_cancel(n);
    check(n == 21, "R6 idle timeout cycle", n, 21);
  endtask

  task automatic t_sticky();
    for (int c = 0; c < 24; c++) begin
      if (c % 4 == 0) sclk = ~sclk;
      @(negedge clk);
    end
    check(cancel_next_cycle, "R8 flag sticky despite sclk edges", cancel_next_cycle, 1);
    cancel_ack = 1'b1; @(negedge clk); cancel_ack = 1'b0;
    check(!cancel_next_cycle, "R8 flag cleared by ack", cancel_next_cycle, 0);
  endtask

  task automatic t_sclk_toggle();
    bit seen = 1'b0;
    sclk_limit = 10'd20;
    for (int c = 0; c < 120; c++) begin
      if (c % 4 == 0) sclk = ~sclk;
      @(negedge clk); seen |= cancel_next_cycle;
    end
    check(!seen, "R7 running sclk keeps flag low", seen, 0);
    sclk_limit = 10'd1000;
    cancel_ack = 1'b1; @(negedge clk); cancel_ack = 1'b0;
  endtask

  task automatic access(input logic [NB-1:0] b);
    bank_sel = b; bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0; bank_sel = '0;
  endtask

  task automatic ack_miss();
    page_miss_ack = 1'b1; @(negedge clk); page_miss_ack = 1'b0;
  endtask

  task automatic t_banks();
    access(4'b0001);
    check(page_miss, "R9 access with no open page misses", page_miss, 1);
    ack_miss();
    check(!page_miss, "R11 miss cleared by ack", page_miss, 0);
    access(4'b0001);
    check(!page_miss, "R9 same bank hits", page_miss, 0);
    access(4'b0100);
    check(page_miss, "R9 bank change misses", page_miss, 1);
    repeat (3) @(negedge clk);
    check(page_miss, "R11 miss held without ack", page_miss, 1);
    ack_miss();
    access(4'b0100);
    check(!page_miss, "R9 return to open bank hits", page_miss, 0);
  endtask

  task automatic t_refresh_closes();
    int n;
    strobe_limit = 10'd10;
    strobe_active = 1'b1;
    count_until_req(n);
    pulse_refresh_ack();
    access(4'b0100);
    check(page_miss, "R10 refresh closes the page", page_miss, 1);
    ack_miss();
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
          $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
          $finish;
        end
      end
    join_none
    t_reset();
    t_strobe_threshold(40);
    t_strobe_threshold(17);
    t_short_pulses();
    t_small_limit();
    t_sclk_idle();
    t_sticky();
    t_sclk_toggle();
    t_banks();
    t_refresh_closes();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule